// File: doc/BRIEF.md
# Lamp Channel Fault Supervisor

This block sequences one cold-cathode lamp channel through four states: idle, strike, run and a latched fault. It watches two supply-good flags and four comparator flags that the analog front end has already sampled. The comparator flags report that lamp current is present, that current is above the regulation level, that current is too high, and that lamp voltage has reached its limit. A strobe marks each lamp-frequency cycle. From these inputs the block produces a channel enable, a strike-mode flag, a fault flag and a gate-duty command for the pulse generator that follows it.

In strike, the duty command climbs one step per lamp cycle until current appears. If lamp voltage is at its limit, the duty holds instead of rising. In run, the duty moves one step per lamp cycle to hold lamp current at the regulation level, and it never rises while the voltage limit is flagged. All timeouts are counted in lamp cycles. Three conditions end in a latched fault: failure to strike, voltage held at its limit during strike, and lamp-out during run. Overcurrent trips the fault at once, without waiting for a lamp cycle. A device with two lamps uses two instances of this block, so a fault in one channel leaves the other running.

Top module: `lampch_supervisor`

## Requirements
- R1: After reset, and on any clock edge where `vdd_ok` or `inv_ok` is low, the block is idle: `ch_en`=0, `strike_mode`=0, `faulted`=0 and `duty_cmd`=0.
- R2: From idle, the first clock edge with both supply flags high enters strike: `ch_en`=1, `strike_mode`=1, `duty_cmd`=0.
- R3: In strike, each `cyc_tick` with `cur_present`=0 and `volt_limit`=0 raises `duty_cmd` by 1, saturating at 2^DUTY_W-1. `duty_cmd` never changes on a clock without `cyc_tick` while the channel is enabled.
- R4: In strike, a `cyc_tick` with `volt_limit`=1 and `cur_present`=0 leaves `duty_cmd` unchanged.
- R5: In strike, a `cyc_tick` with `cur_present`=1 moves to run (`strike_mode`=0, `ch_en`=1) and keeps the current `duty_cmd`.
- R6: If STRIKE_CYC ticks without `cur_present` occur in one strike attempt, the channel enters fault on the last of them (`ch_en`=0, `faulted`=1, `duty_cmd`=0).
- R7: In strike, a voltage integrator counts up on each tick with `volt_limit`=1 and down, stopping at 0, on each tick without it. When it reaches OV_WIN, the channel enters fault.
- R8: In run, each `cyc_tick` raises `duty_cmd` by 1 (saturating at max) when `cur_above_reg`=0 and `volt_limit`=0. Otherwise it lowers `duty_cmd` by 1, stopping at 0.
- R9: In run, LAMPOUT_CYC consecutive ticks with `cur_present`=0 put the channel in fault. A tick with `cur_present`=1 restarts the count.
- R10: `cur_over`=1 in strike or run puts the channel in fault at the next clock edge, whether or not `cyc_tick` is high.
- R11: Fault persists, whatever the comparator and tick inputs do, until a supply flag goes low. The block then returns to idle and can strike again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vdd_ok | input | 1 | Device supply above its lockout level |
| inv_ok | input | 1 | Inverter supply monitor above its threshold |
| cyc_tick | input | 1 | One-clock strobe per lamp cycle |
| cur_present | input | 1 | Lamp current above the lamp-out level |
| cur_above_reg | input | 1 | Lamp current above the regulation level |
| cur_over | input | 1 | Lamp overcurrent |
| volt_limit | input | 1 | Lamp voltage at the overvoltage threshold |
| ch_en | output | 1 | Gate drive enabled (strike or run) |
| strike_mode | output | 1 | Channel is striking (boosted frequency) |
| faulted | output | 1 | Channel is in the latched fault |
| duty_cmd | output | DUTY_W | Gate duty command |

## Verification
The duty path is driven with tick trains in strike that mix voltage-limited ticks with free ones. This separates holding from ramping, and it reaches saturation. In run, every combination of the regulation flag and the voltage flag is swept, with the expected duty worked out step by step, and long runs pin the counter at full scale and at zero. The timeouts are tested with patterns that end one tick short of the limit and then exactly at it. The voltage integrator gets an up-down-up pattern that shows it counts down rather than resetting. Overcurrent is applied without a tick in both strike and run, and stimulus applied during fault shows that the fault stays latched until a supply flag drops.

// File: rtl/lampch_pkg.sv
package lampch_pkg;
  typedef enum logic [1:0] {
    CH_IDLE   = 2'd0,
    CH_STRIKE = 2'd1,
    CH_RUN    = 2'd2,
    CH_FAULT  = 2'd3
  } ch_state_e;
endpackage

// File: rtl/lampch_cyc_cnt.sv
// Lamp-cycle timeout counter: hit pulses on the LIMIT-th counted cycle.
module lampch_cyc_cnt #(
  parameter int LIMIT = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign hit    = inc && !clr && (cnt_q == LAST);
  assign cnt_en = clr || inc;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lampch_ov_integ.sv
// Up/down overvoltage integrator over lamp cycles, floor at zero.
module lampch_ov_integ #(
  parameter int WIN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic ov,
  output logic trip
);
  localparam int IW = $clog2(WIN + 1);
  localparam logic [IW-1:0] LAST = IW'(WIN - 1);

  logic [IW-1:0] acc_q, acc_d;
  logic          acc_en;

  assign trip   = tick && ov && !clr && (acc_q == LAST);
  assign acc_en = clr || tick;

  always_comb begin
    acc_d = acc_q;
    if (clr)                 acc_d = '0;
    else if (tick && ov)     acc_d = acc_q + IW'(1);
    else if (tick && acc_q != '0) acc_d = acc_q - IW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end
endmodule

// File: rtl/lampch_duty.sv
// Gate duty command: ramp in strike, one-step regulation in run.
module lampch_duty #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ramp_en,
  input  logic         reg_en,
  input  logic         v_lim,
  input  logic         above_reg,
  output logic [W-1:0] duty
);
  localparam logic [W-1:0] DMAX = '1;

  logic [W-1:0] duty_d;
  logic         duty_en;

  assign duty_en = clr || ramp_en || reg_en;

  always_comb begin
    duty_d = duty;
    if (clr) begin
      duty_d = '0;
    end else if (ramp_en) begin
      if (!v_lim && duty != DMAX) duty_d = duty + W'(1);
    end else if (reg_en) begin
      if (!above_reg && !v_lim) begin
        if (duty != DMAX) duty_d = duty + W'(1);
      end else if (duty != '0) begin
        duty_d = duty - W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       duty <= '0;
    else if (duty_en) duty <= duty_d;
  end
endmodule

// File: rtl/lampch_supervisor.sv
module lampch_supervisor
  import lampch_pkg::*;
#(
  parameter int DUTY_W      = 8,
  parameter int STRIKE_CYC  = 65536,
  parameter int LAMPOUT_CYC = 65536,
  parameter int OV_WIN      = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vdd_ok,
  input  logic              inv_ok,
  input  logic              cyc_tick,
  input  logic              cur_present,
  input  logic              cur_above_reg,
  input  logic              cur_over,
  input  logic              volt_limit,
  output logic              ch_en,
  output logic              strike_mode,
  output logic              faulted,
  output logic [DUTY_W-1:0] duty_cmd
);
  ch_state_e st_q, st_d;
  logic supply_ok, in_strike, in_run;
  logic strike_hit, lampout_hit, ov_trip;
  logic duty_clr;

  assign supply_ok = vdd_ok && inv_ok;
  assign in_strike = (st_q == CH_STRIKE);
  assign in_run    = (st_q == CH_RUN);

  lampch_cyc_cnt #(.LIMIT(STRIKE_CYC)) u_strike_to (
    .clk(clk), .rst_n(rst_n),
    .clr(!in_strike),
    .inc(in_strike && cyc_tick && !cur_present),
    .hit(strike_hit)
  );

  lampch_cyc_cnt #(.LIMIT(LAMPOUT_CYC)) u_lampout_to (
    .clk(clk), .rst_n(rst_n),
    .clr(!in_run || (cyc_tick && cur_present)),
    .inc(in_run && cyc_tick && !cur_present),
    .hit(lampout_hit)
  );

  lampch_ov_integ #(.WIN(OV_WIN)) u_ov (
    .clk(clk), .rst_n(rst_n),
    .clr(!in_strike),
    .tick(in_strike && cyc_tick),
    .ov(volt_limit),
    .trip(ov_trip)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      CH_IDLE:   if (supply_ok) st_d = CH_STRIKE;
      CH_STRIKE: begin
        if (cur_over) st_d = CH_FAULT;
        else if (cyc_tick) begin
          if (ov_trip)          st_d = CH_FAULT;
          else if (cur_present) st_d = CH_RUN;
          else if (strike_hit)  st_d = CH_FAULT;
        end
      end
      CH_RUN: begin
        if (cur_over || lampout_hit) st_d = CH_FAULT;
      end
      CH_FAULT:  st_d = CH_FAULT;
      default:   st_d = CH_IDLE;
    endcase
    if (!supply_ok) st_d = CH_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= CH_IDLE;
    else        st_q <= st_d;
  end

  assign duty_clr = (st_d == CH_IDLE) || (st_d == CH_FAULT);

  lampch_duty #(.W(DUTY_W)) u_duty (
    .clk(clk), .rst_n(rst_n),
    .clr(duty_clr),
    .ramp_en(in_strike && cyc_tick && !cur_present),
    .reg_en(in_run && cyc_tick),
    .v_lim(volt_limit),
    .above_reg(cur_above_reg),
    .duty(duty_cmd)
  );

  assign ch_en       = in_strike || in_run;
  assign strike_mode = in_strike;
  assign faulted     = (st_q == CH_FAULT);
endmodule

// File: rtl/lampch_supervisor_chk.sv
module lampch_supervisor_chk #(
  parameter int DUTY_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vdd_ok,
  input logic              inv_ok,
  input logic              cyc_tick,
  input logic              cur_over,
  input logic              volt_limit,
  input logic              ch_en,
  input logic              strike_mode,
  input logic              faulted,
  input logic [DUTY_W-1:0] duty_cmd
);
  // R1
  supply_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(vdd_ok && inv_ok) |=> (!ch_en && !faulted && duty_cmd == '0));

  // R2
  idle_to_strike_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_en && !faulted && vdd_ok && inv_ok) |=> strike_mode);

  // R3
  duty_tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en && !cyc_tick && vdd_ok && inv_ok && !cur_over) |=> (!ch_en || $stable(duty_cmd)));

  // R8
  duty_one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_en |=> (!ch_en || duty_cmd == $past(duty_cmd) ||
               duty_cmd == $past(duty_cmd) + 1 || duty_cmd + 1 == $past(duty_cmd)));

  // R4
  strike_vlim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strike_mode && cyc_tick && volt_limit) |=> (duty_cmd <= $past(duty_cmd)));

  // R10
  overcurrent_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en && cur_over && vdd_ok && inv_ok) |=> faulted);

  // R11
  fault_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (faulted && vdd_ok && inv_ok) |=> (faulted && !ch_en));
endmodule

bind lampch_supervisor lampch_supervisor_chk #(.DUTY_W(DUTY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .vdd_ok(vdd_ok), .inv_ok(inv_ok),
  .cyc_tick(cyc_tick), .cur_over(cur_over), .volt_limit(volt_limit),
  .ch_en(ch_en), .strike_mode(strike_mode), .faulted(faulted),
  .duty_cmd(duty_cmd)
);

// File: tb/sim_lampch_supervisor.sv
module sim_lampch_supervisor;
  localparam int CLK_P  = 10;
  localparam int DW     = 4;
  localparam int DMAX   = 15;
  localparam int S_CYC  = 24;
  localparam int LO_CYC = 10;
  localparam int OVW    = 6;

  logic clk = 1'b0;
  logic rst_n, vdd_ok, inv_ok, cyc_tick, cur_present, cur_above_reg, cur_over, volt_limit;
  logic ch_en, strike_mode, faulted;
  logic [DW-1:0] duty_cmd;

  int n_chk = 0;
  int n_bad = 0;
  int exp_d;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  lampch_supervisor #(.DUTY_W(DW), .STRIKE_CYC(S_CYC), .LAMPOUT_CYC(LO_CYC), .OV_WIN(OVW)) u0 (
    .clk(clk), .rst_n(rst_n), .vdd_ok(vdd_ok), .inv_ok(inv_ok), .cyc_tick(cyc_tick),
    .cur_present(cur_present), .cur_above_reg(cur_above_reg), .cur_over(cur_over),
    .volt_limit(volt_limit), .ch_en(ch_en), .strike_mode(strike_mode),
    .faulted(faulted), .duty_cmd(duty_cmd)
  );

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // state code: 0 idle, 1 strike, 2 run, 3 fault
  function automatic int st_code();
    if (faulted) return 3;
    if (strike_mode) return 1;
    if (ch_en) return 2;
    return 0;
  endfunction

  task automatic step(input logic t);
    cyc_tick = t;
    @(posedge clk);
    #1;
    cyc_tick = 1'b0;
  endtask

  task automatic restart();
    vdd_ok = 1'b0; cur_present = 0; cur_above_reg = 0; cur_over = 0; volt_limit = 0;
    step(1'b0);
    chk("R1 idle after supply drop", st_code(), 0);
    chk("R1 duty idle", int'(duty_cmd), 0);
    vdd_ok = 1'b1;
    step(1'b0);
    chk("R2 strike entry", st_code(), 1);
    chk("R2 duty at strike entry", int'(duty_cmd), 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; vdd_ok = 0; inv_ok = 0; cyc_tick = 0;
    cur_present = 0; cur_above_reg = 0; cur_over = 0; volt_limit = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step(1'b0);
    chk("R1 reset state", st_code(), 0);
    chk("R1 reset duty", int'(duty_cmd), 0);

    // only one supply good at a time
    vdd_ok = 1;
    for (int i = 0; i < 3; i++) begin step(1'b1); chk("R1 inverter supply low", st_code(), 0); end
    vdd_ok = 0; inv_ok = 1;
    for (int i = 0; i < 3; i++) begin step(1'b1); chk("R1 device supply low", st_code(), 0); end
    vdd_ok = 1;
    step(1'b0);
    chk("R2 both supplies good", st_code(), 1);

    // strike ramp, voltage hold, then timeout
    exp_d = 0;
    for (int i = 1; i <= S_CYC; i++) begin
      volt_limit = (i >= 6 && i <= 8);
      if (!volt_limit && exp_d < DMAX) exp_d++;
      step(1'b1);
      if (i < S_CYC) begin
        chk("R6 strike before timeout", st_code(), 1);
        chk(volt_limit ? "R4 duty held at voltage limit" : "R3 strike ramp", int'(duty_cmd), exp_d);
        step(1'b0);
        chk("R3 no change without tick", int'(duty_cmd), exp_d);
      end else begin
        chk("R6 strike timeout fault", st_code(), 3);
        chk("R6 duty cleared in fault", int'(duty_cmd), 0);
      end
    end
    volt_limit = 0;

    // fault stays latched under any stimulus
    for (int i = 0; i < 8; i++) begin
      cur_present = i[0]; cur_over = i[1]; volt_limit = i[2];
      step(1'b1);
      chk("R11 fault latched", st_code(), 3);
    end
    cur_present = 0; cur_over = 0; volt_limit = 0;
    inv_ok = 0; step(1'b0);
    chk("R11 fault cleared by inverter supply", st_code(), 0);
    inv_ok = 1; step(1'b0);
    chk("R11 restrike after clear", st_code(), 1);

    // overvoltage integrator: up 4, down 2, up 3 (no trip), up 1 trips
    volt_limit = 1; repeat (4) step(1'b1);
    chk("R7 no trip at 4", st_code(), 1);
    volt_limit = 0; repeat (2) step(1'b1);
    chk("R3 ramp after voltage clears", int'(duty_cmd), 2);
    volt_limit = 1; repeat (3) step(1'b1);
    chk("R7 integrator counted down", st_code(), 1);
    step(1'b1);
    chk("R7 overvoltage trip", st_code(), 3);
    volt_limit = 0;

    // strike to run
    restart();
    repeat (3) step(1'b1);
    cur_present = 1; step(1'b1);
    chk("R5 struck enters run", st_code(), 2);
    chk("R5 duty kept", int'(duty_cmd), 3);

    // regulation sweep
    exp_d = 3;
    for (int c = 0; c < 4; c++) begin
      cur_above_reg = c[0]; volt_limit = c[1];
      for (int k = 0; k < 6; k++) begin
        if (!cur_above_reg && !volt_limit) exp_d = (exp_d < DMAX) ? exp_d + 1 : DMAX;
        else exp_d = (exp_d > 0) ? exp_d - 1 : 0;
        step(1'b1);
        chk("R8 run regulation", int'(duty_cmd), exp_d);
      end
    end
    cur_above_reg = 0; volt_limit = 0;
    for (int k = 0; k < 20; k++) begin
      exp_d = (exp_d < DMAX) ? exp_d + 1 : DMAX;
      step(1'b1);
    end
    chk("R8 saturates at max", int'(duty_cmd), DMAX);
    cur_above_reg = 1;
    for (int k = 0; k < 20; k++) step(1'b1);
    chk("R8 floors at zero", int'(duty_cmd), 0);
    cur_above_reg = 0;

    // lamp-out
    cur_present = 0;
    repeat (LO_CYC - 1) step(1'b1);
    chk("R9 run one short of lamp-out", st_code(), 2);
    cur_present = 1; step(1'b1);
    cur_present = 0;
    repeat (LO_CYC - 1) step(1'b1);
    chk("R9 count restarted by current", st_code(), 2);
    step(1'b1);
    chk("R9 lamp-out fault", st_code(), 3);

    // overcurrent without tick, strike and run
    restart();
    cur_over = 1; step(1'b0);
    chk("R10 overcurrent in strike", st_code(), 3);
    restart();
    cur_present = 1; step(1'b1);
    chk("R5 run entry", st_code(), 2);
    cur_over = 1; step(1'b0);
    chk("R10 overcurrent in run", st_code(), 3);
    cur_over = 0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule